// File: doc/BRIEF.md
# Ready-Polled Serial ADC Reader

This block is the host side of a two-wire link to a delta-sigma converter. The converter signals a finished conversion by pulling a shared ready/data line low. The same line then carries the result bits, one per serial clock pulse. The reader watches that line through a synchronizer. When it sees the line low while idle, it drives a serial clock with a programmable high and low width. It captures up to 24 result bits, most significant first, and sets the remaining low-order bits of the result to zero.

After the last data bit, the reader can send one extra clock that makes the converter release the line high. Without that extra clock, the line may stay low if the last bit was zero, which looks like a fresh ready signal. In that case the reader does not accept a new ready signal until it has seen the line high again.

A finished word is presented on a parallel output together with a one-cycle strobe. A read that does not finish within a programmed number of system clocks is abandoned and reported with an overrun strobe. This protects against reading data that the converter's next update has already overwritten.

Top module: `adc_ready_reader`

## Requirements
- R1: While reset is held, and in the first cycle after it, `adc_sclk`, `data_valid` and `overrun` are 0 and `data_out` is all zeros.
- R2: A read starts only from the idle state, and only when the synchronized line is low. While the line stays high, no serial clock pulse is produced.
- R3: During a read, every serial clock high phase and every low phase between two pulses lasts exactly `cfg_half_period` system clocks. Values below 2 are treated as 2.
- R4: A read takes N data bits. N is `cfg_nbits`, and a value of 0 or above 24 means 24. The bit presented after rising edge k (k = 0 first) is stored at `data_out[23-k]`. Bits `data_out[23-N:0]` are 0. The line is sampled in the last system clock of the low phase that follows each rising edge.
- R5: The number of rising serial clock edges in a completed read is N, or N+1 when `cfg_park` is 1. The extra pulse is not captured.
- R6: A completed read gives `data_valid` high for exactly one cycle, with the new word on `data_out` in that same cycle. `data_out` changes at no other time.
- R7: After a read ends, whether completed or abandoned, a line that stays low does not start another read. Ready detection is re-armed only after the synchronized line has been seen high.
- R8: Let HP be the effective `cfg_half_period` from R3. A read completes only if `cfg_timeout` is at least 2·HP·N. Otherwise `overrun` pulses for one cycle, the serial clock stops low, no `data_valid` is produced, and `data_out` keeps its previous value.
- R9: The line passes through two synchronizer flops. The first rising serial clock edge appears at the third system clock edge after the line goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_half_period | input | HP_W | Serial clock high/low phase length in system clocks |
| cfg_nbits | input | NB_W | Number of bits per read (0 means full width) |
| cfg_park | input | 1 | Send one extra pulse after the data to force the line high |
| cfg_timeout | input | TO_W | Read budget in system clocks from the first pulse |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_rdy_dout | input | 1 | Shared ready / serial data line from the converter |
| data_out | output | DATA_W | Last captured word, left-aligned, zero-filled |
| data_valid | output | 1 | One-cycle strobe for a new word |
| overrun | output | 1 | One-cycle strobe for an abandoned read |

## Verification
The hardest case to reach is a read that ends with a zero bit while no parking pulse is enabled. The line then stays low after the read, exactly as it does when a new conversion is ready. The stimulus uses result words whose least significant bit is zero and holds the line low for forty cycles after the strobe, before any update happens; during that time no serial clock pulse may appear. The overrun limit is checked on both sides of its boundary. A budget one cycle short of 2·HP·N must abandon the read, and a budget of exactly 2·HP·N must complete it.

// File: rtl/rdr_pkg.sv
// Shared types for the ready-polled serial reader.
package rdr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_HI     = 3'd1,
        ST_LO     = 3'd2,
        ST_DONE   = 3'd3,
        ST_WAITHI = 3'd4
    } rdr_state_e;
endpackage

// File: rtl/rdr_sync.sv
// Multi-flop synchronizer for the shared ready/data line.
// Assumes the idle level of the line is high, so it resets to 1.
module rdr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rdr_phase_timer.sv
// Counts system clocks within a serial clock phase and pulses tick in the
// last cycle of each phase. Assumes run is held through consecutive phases.
module rdr_phase_timer #(
    parameter int HP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [HP_W-1:0] half_period,
    output logic            tick
);
    logic [HP_W-1:0] cnt;
    logic [HP_W-1:0] hp_eff;

    // Clamp the phase length to a floor of two cycles.
    always_comb hp_eff = (half_period < HP_W'(2)) ? HP_W'(2) : half_period;

    assign tick = run && (cnt == hp_eff - HP_W'(1));

    // Advance the phase counter, restarting at each phase boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + HP_W'(1);
    end
endmodule

// File: rtl/rdr_capture.sv
// Result register: cleared at the start of a read, then written one bit at
// a time at the position given by idx counted from the MSB.
module rdr_capture #(
    parameter int W  = 24,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [IW-1:0] idx,
    input  logic          bitv,
    output logic [W-1:0]  word
);
    // Clear or store one sampled bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            word <= '0;
        end else if (en) begin
            for (int i = 0; i < W; i++) begin
                if (idx == IW'(W - 1 - i)) word[i] <= bitv;
            end
        end
    end
endmodule

// File: rtl/rdr_ctrl.sv
// Read sequencer: detects ready, steps serial clock phases, counts bits,
// sends the optional parking pulse, enforces the read budget and re-arms
// only after the line is seen high. Assumes configuration is stable while
// a read is in progress.
module rdr_ctrl
    import rdr_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int NB_W   = 5,
    parameter int IW     = 5,
    parameter int TO_W   = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_s,
    input  logic            tick,
    input  logic [NB_W-1:0] nbits,
    input  logic            park,
    input  logic [TO_W-1:0] timeout,
    output logic            sclk_o,
    output logic            run,
    output logic            cap_clr,
    output logic            cap_en,
    output logic [IW-1:0]   cap_idx,
    output logic            done,
    output logic            ovr_o
);
    rdr_state_e      st, st_n;
    logic [NB_W-1:0] bit_idx;
    logic [NB_W-1:0] nb_eff;
    logic [TO_W-1:0] to_cnt;
    logic            parking;
    logic            last_bit;
    logic            to_hit;
    logic            ovr_n;

    // Resolve the configured bit count to a legal value.
    always_comb nb_eff = (nbits == '0 || nbits > NB_W'(DATA_W)) ? NB_W'(DATA_W) : nbits;

    assign last_bit = (bit_idx == nb_eff - NB_W'(1));
    assign run      = (st == ST_HI) || (st == ST_LO);
    assign to_hit   = run && !parking && (to_cnt == timeout);
    assign cap_idx  = bit_idx[IW-1:0];
    assign done     = (st == ST_DONE);

    // Next-state and capture strobes.
    always_comb begin
        st_n    = st;
        cap_clr = 1'b0;
        cap_en  = 1'b0;
        ovr_n   = 1'b0;
        case (st)
            ST_IDLE: if (!line_s) begin
                st_n    = ST_HI;
                cap_clr = 1'b1;
            end
            ST_HI: begin
                if (to_hit) begin
                    ovr_n = 1'b1;
                    st_n  = ST_WAITHI;
                end else if (tick) begin
                    st_n = ST_LO;
                end
            end
            ST_LO: begin
                if (to_hit) begin
                    ovr_n = 1'b1;
                    st_n  = ST_WAITHI;
                end else if (tick) begin
                    if (parking) begin
                        st_n = ST_DONE;
                    end else begin
                        cap_en = 1'b1;
                        if (!last_bit) st_n = ST_HI;
                        else if (park) st_n = ST_HI;
                        else           st_n = ST_DONE;
                    end
                end
            end
            ST_DONE:   st_n = ST_WAITHI;
            ST_WAITHI: if (line_s) st_n = ST_IDLE;
            default:   st_n = ST_IDLE;
        endcase
    end

    // State, registered serial clock and overrun strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            sclk_o <= 1'b0;
            ovr_o  <= 1'b0;
        end else begin
            st     <= st_n;
            sclk_o <= (st_n == ST_HI);
            ovr_o  <= ovr_n;
        end
    end

    // Bit counter, parking flag and read budget counter.
    always_ff @(posedge clk) begin
        if (!rst_n || st == ST_IDLE) begin
            bit_idx <= '0;
            parking <= 1'b0;
            to_cnt  <= '0;
        end else begin
            if (cap_en) bit_idx <= bit_idx + NB_W'(1);
            if (cap_en && last_bit && park) parking <= 1'b1;
            if (run && !parking && !to_hit) to_cnt <= to_cnt + TO_W'(1);
        end
    end

    // R2: a pulse out of idle requires the synchronized line to have been low.
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |=> (!sclk_o || !$past(line_s)));

    // R3: the serial clock level holds between phase boundaries.
    a_r3_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !to_hit) |=> $stable(sclk_o));

    // R7: a low line after a read never re-enters idle.
    a_r7_rearm_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAITHI && !line_s) |=> (st != ST_IDLE && !sclk_o));

    // R4: the bit index never passes the configured count.
    a_r4_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx <= nb_eff);
endmodule

// File: rtl/adc_ready_reader.sv
// Top of the ready-polled serial reader. Wires the synchronizer, phase
// timer, sequencer and capture register, and registers the result word and
// its strobe. Assumes the converter changes its data line after each rising
// serial clock edge.
module adc_ready_reader #(
    parameter int DATA_W = 24,
    parameter int HP_W   = 8,
    parameter int TO_W   = 20,
    parameter int NB_W   = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HP_W-1:0]   cfg_half_period,
    input  logic [NB_W-1:0]   cfg_nbits,
    input  logic              cfg_park,
    input  logic [TO_W-1:0]   cfg_timeout,
    output logic              adc_sclk,
    input  logic              adc_rdy_dout,
    output logic [DATA_W-1:0] data_out,
    output logic              data_valid,
    output logic              overrun
);
    localparam int IW = $clog2(DATA_W);

    logic              line_s;
    logic              tick;
    logic              run;
    logic              cap_clr;
    logic              cap_en;
    logic [IW-1:0]     cap_idx;
    logic              done;
    logic [DATA_W-1:0] word;

    rdr_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (adc_rdy_dout),
        .q     (line_s)
    );

    rdr_phase_timer #(.HP_W(HP_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .half_period (cfg_half_period),
        .tick        (tick)
    );

    rdr_ctrl #(.DATA_W(DATA_W), .NB_W(NB_W), .IW(IW), .TO_W(TO_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_s  (line_s),
        .tick    (tick),
        .nbits   (cfg_nbits),
        .park    (cfg_park),
        .timeout (cfg_timeout),
        .sclk_o  (adc_sclk),
        .run     (run),
        .cap_clr (cap_clr),
        .cap_en  (cap_en),
        .cap_idx (cap_idx),
        .done    (done),
        .ovr_o   (overrun)
    );

    rdr_capture #(.W(DATA_W), .IW(IW)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cap_clr),
        .en    (cap_en),
        .idx   (cap_idx),
        .bitv  (line_s),
        .word  (word)
    );

    // Present a finished word with its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out   <= '0;
            data_valid <= 1'b0;
        end else begin
            data_valid <= done;
            if (done) data_out <= word;
        end
    end

    // R6: the result strobe lasts one cycle.
    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid);

    // R6: the result word only moves together with the strobe.
    a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_out) |-> data_valid);

    // R8: an abandoned read never reports a result in the same cycle.
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !data_valid);

    // R8: the overrun strobe lasts one cycle and leaves the clock low.
    a_r8_ovr_single: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> (!adc_sclk && !$past(overrun)));
endmodule

// File: tb/sim_adc_ready_reader.sv
`timescale 1ns/1ps
module sim_adc_ready_reader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_half_period = 8'd3;
    logic [4:0]  cfg_nbits = 5'd24;
    logic        cfg_park = 1'b0;
    logic [19:0] cfg_timeout = 20'd100000;
    logic        adc_sclk;
    logic        line = 1'b1;
    logic [23:0] data_out;
    logic        data_valid;
    logic        overrun;

    int checks = 0;
    int errors = 0;
    int cur_hp = 3;
    int rises = 0;
    int len = 0;
    logic prev_sclk = 1'b0;
    logic [23:0] dev_word = '0;
    int dev_idx = 99;
    logic [23:0] last_out = '0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    adc_ready_reader u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_half_period (cfg_half_period),
        .cfg_nbits       (cfg_nbits),
        .cfg_park        (cfg_park),
        .cfg_timeout     (cfg_timeout),
        .adc_sclk        (adc_sclk),
        .adc_rdy_dout    (line),
        .data_out        (data_out),
        .data_valid      (data_valid),
        .overrun         (overrun)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Converter model: each rising serial clock edge presents the next bit;
    // after the last bit, one more edge releases the line high.
    always @(posedge adc_sclk) begin
        if (dev_idx < 24) begin
            line <= dev_word[23 - dev_idx];
            dev_idx <= dev_idx + 1;
        end else begin
            line <= 1'b1;
        end
    end

    // Reference monitor, evaluated every clock: phase widths and edge count.
    always @(negedge clk) begin
        if (rst_n) begin
            if (adc_sclk !== prev_sclk) begin
                if (prev_sclk === 1'b1 && !overrun)
                    chk(len == cur_hp, "R3 high phase width", len, cur_hp);
                else if (prev_sclk === 1'b0 && rises > 0)
                    chk(len == cur_hp, "R3 low phase width", len, cur_hp);
                if (adc_sclk === 1'b1) rises++;
                len = 1;
            end else begin
                len++;
            end
            prev_sclk = adc_sclk;
        end
    end

    task automatic do_read(input logic [23:0] word, input int n, input bit pk,
                           input int hp, input int to, input bit exp_ovr);
        int ne;
        int k;
        int r0;
        bit got_v;
        bit got_o;
        logic [23:0] exp_word;
        ne = (n == 0 || n > 24) ? 24 : n;
        exp_word = word & ~((24'h1 << (24 - ne)) - 24'h1);
        @(negedge clk);
        cfg_half_period = 8'(hp);
        cfg_nbits = 5'(n);
        cfg_park = pk;
        cfg_timeout = 20'(to);
        cur_hp = hp;
        dev_idx = 99;
        line = 1'b1;
        r0 = rises;
        repeat (10) @(negedge clk);
        chk(rises == r0, "R2 no pulse while line high", rises - r0, 0);
        dev_word = word;
        dev_idx = 0;
        rises = 0;
        line = 1'b0;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!adc_sclk && k < 20);
        chk(k == 3, "R9 ready-to-first-edge latency", k, 3);
        got_v = 0;
        got_o = 0;
        for (int c = 0; c < 20000 && !got_v && !got_o; c++) begin
            if (c > 0) @(negedge clk);
            if (data_valid) got_v = 1;
            if (overrun) got_o = 1;
        end
        if (exp_ovr) begin
            chk(got_o, "R8 overrun reported", got_o, 1);
            chk(!got_v, "R8 no result strobe", got_v, 0);
            chk(data_out == last_out, "R8 output unchanged", data_out, last_out);
        end else begin
            chk(got_v, "R6 result strobe", got_v, 1);
            chk(!got_o, "R8 no overrun", got_o, 0);
            chk(data_out == exp_word, "R4 captured word", data_out, exp_word);
            chk(rises == ne + (pk ? 1 : 0), "R5 edge count", rises, ne + (pk ? 1 : 0));
            last_out = exp_word;
            @(negedge clk);
            chk(!data_valid, "R6 strobe single cycle", data_valid, 0);
        end
        r0 = rises;
        repeat (40) @(negedge clk);
        chk(rises == r0, "R7 no re-read before line high", rises - r0, 0);
        chk(data_out == last_out, "R6 output held", data_out, last_out);
        dev_idx = 99;
        line = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(adc_sclk == 1'b0 && data_valid == 1'b0 && overrun == 1'b0 && data_out == '0,
            "R1 outputs during reset", {adc_sclk, data_valid, overrun, data_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(adc_sclk == 1'b0 && data_valid == 1'b0 && overrun == 1'b0 && data_out == '0,
            "R1 outputs after reset", {adc_sclk, data_valid, overrun, data_out}, 0);
        // R7: low final bit, no parking pulse.
        do_read(24'hA5C396, 24, 0, 3, 100000, 0);
        // R5: parking pulse adds one edge.
        do_read(24'h5A0F3C, 24, 1, 2, 100000, 0);
        // R4: partial read, zero fill.
        do_read(24'hFFFFFF, 12, 0, 4, 100000, 0);
        do_read(24'h800001, 1, 0, 5, 100000, 0);
        // R8: one cycle short of 2*HP*N, then exactly 2*HP*N.
        do_read(24'h3C3C3C, 24, 0, 3, 143, 1);
        do_read(24'h123456, 24, 0, 3, 144, 0);
        // R4: count 0 means full width; R5 with parking.
        do_read(24'h0F0F0F, 0, 1, 2, 100000, 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule